// File: doc/BRIEF.md
# Serial Character Framer with Line Control

This block turns parallel bytes into an asynchronous serial character stream on a single transmit line. A byte enters through a valid/ready handshake. The framer sends a start bit, then 5 to 8 data bits least significant bit first, then an optional parity bit, then the stop bits. The line control word sets the word length, the stop length, the parity mode and a break override. Parity can be odd, even, forced to one or forced to zero. The bit timing comes from a one-cycle pulse, `baud_tick_i`, made by an external divisor. Every serial bit lasts 16 of these pulses.

Back-pressure works as follows. `s_ready` is high only while the framer is idle. A byte is taken on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` then stays low until the last stop bit has finished. The producer must hold `s_data` steady while `s_valid` is high and `s_ready` is low. The framer copies the line settings at the moment it takes a byte, so a settings change only affects the next character. The break override is the exception: it acts on the line at once.

The block also decodes the access window of the line control word. Bit 7 of that word sends register offsets 0 to 2 either to the data-side register group or to the divisor register group (low, high, fractional).

Top module: `uart_txf_top`

## Requirements
- R1: After reset, `txd_o` is 1 (idle line), `s_ready` is 1, and with `reg_en_i` low both select vectors are zero.
- R2: A byte is accepted on a clock edge where `s_valid` and `s_ready` are both 1. `s_ready` is 0 from the next cycle until the frame ends, and changes on `s_data` while the framer is busy have no effect on the line.
- R3: A frame starts with a 0 start bit. The data bits follow least significant bit first. The number of data bits is 5, 6, 7 or 8 for `lcr_i[1:0]` = 00, 01, 10 or 11.
- R4: Each start, data and parity bit lasts exactly 16 `baud_tick_i` pulses, counted from the first pulse after the accepting edge.
- R5: When `lcr_i[3]` is 0, no parity bit is sent and the stop bits follow the last data bit directly.
- R6: When `lcr_i[3]` is 1 and `lcr_i[5:4]` is 00, the parity bit makes the number of ones in the data bits plus the parity bit odd.
- R7: When `lcr_i[3]` is 1 and `lcr_i[5:4]` is 01, the parity bit makes that number of ones even.
- R8: When `lcr_i[3]` is 1 and `lcr_i[5:4]` is 10, the parity bit is always 1.
- R9: When `lcr_i[3]` is 1 and `lcr_i[5:4]` is 11, the parity bit is always 0.
- R10: The stop bits are 1. With `lcr_i[2]` = 0 they last 16 pulses. With `lcr_i[2]` = 1 they last 32 pulses, or 24 pulses when the word length is 5. `s_ready` returns to 1 in the cycle after the last stop pulse is consumed.
- R11: While `lcr_i[6]` is 1, `txd_o` is 0 in the same cycle, idle or busy. Frame timing keeps running, and clearing the bit returns the line to the framer's current bit.
- R12: Changes to `lcr_i[5:0]` during a frame do not alter that frame. The settings are captured at the accepting edge.
- R13: With `reg_en_i` at 1 and `reg_addr_i` = k below 3, `dsel_o[k]` is 1 when `lcr_i[7]` is 0, and `vsel_o[k]` is 1 when `lcr_i[7]` is 1. All other select bits are 0. Addresses 3 and above select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_i | input | 8 | Line control word |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Framer idle, can accept a byte |
| s_data | input | 8 | Byte to send |
| reg_en_i | input | 1 | Register access strobe |
| reg_addr_i | input | 3 | Register offset |
| txd_o | output | 1 | Serial transmit line |
| dsel_o | output | 3 | Data-side register selects, offsets 0..2 |
| vsel_o | output | 3 | Divisor register selects (low, high, fractional) |

## Verification
Two things can act on the line in the same cycle: the break override and the framer's own bit sequencing. The bench raises break mid-frame and also clears it mid-frame. It then checks that the line is 0 wherever break is set, and that it shows the correct framed bit once break is cleared. It also checks that `s_ready` still comes back after the exact number of ticks. Parity settings are changed in the middle of a character in the same way, and that character is judged against the settings captured at its start.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txf_state_e;

  typedef struct packed {
    logic       win_div;
    logic       brk;
    logic       force_par;
    logic       par_even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] wlen;
  } line_ctl_t;

endpackage

// File: rtl/txf_parity.sv
module txf_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_even_i,
  input  logic              force_par_i,
  output logic              pbit_o
);
  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = data_i[i] & (i < 5 + int'(wlen_i));
    end
    ones_odd = ^masked;
    if (force_par_i) pbit_o = ~par_even_i;
    else if (par_even_i) pbit_o = ones_odd;
    else pbit_o = ~ones_odd;
  end
endmodule

// File: rtl/txf_seq.sv
module txf_seq
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        wlen_i,
  input  logic              long_stop_i,
  input  logic              par_en_i,
  input  logic              pbit_i,
  output logic              line_o
);
  localparam int CNT_W = $clog2(2 * OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS + OVS / 2 - 1);

  txf_state_e        state;
  logic [CNT_W-1:0]  tick_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic [1:0]        cfg_wlen;
  logic              cfg_stop;
  logic              cfg_pen;
  logic              par_q;
  logic              line_q;
  logic [CNT_W-1:0]  seg_last;
  logic [BIT_W-1:0]  last_idx;

  assign in_ready = (state == ST_IDLE);
  assign line_o   = line_q;
  assign last_idx = BIT_W'(4) + BIT_W'(cfg_wlen);

  always_comb begin
    seg_last = BIT_LAST;
    if (state == ST_STOP && cfg_stop) begin
      seg_last = (cfg_wlen == 2'b00) ? HALF_LAST : TWO_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      cfg_wlen <= '0;
      cfg_stop <= 1'b0;
      cfg_pen  <= 1'b0;
      par_q    <= 1'b0;
      line_q   <= 1'b1;
    end else if (state == ST_IDLE) begin
      line_q <= 1'b1;
      if (in_valid) begin
        shreg    <= in_data;
        cfg_wlen <= wlen_i;
        cfg_stop <= long_stop_i;
        cfg_pen  <= par_en_i;
        par_q    <= pbit_i;
        tick_cnt <= '0;
        bit_idx  <= '0;
        line_q   <= 1'b0;
        state    <= ST_START;
      end
    end else if (baud_tick) begin
      if (tick_cnt != seg_last) begin
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        tick_cnt <= '0;
        case (state)
          ST_START: begin
            line_q <= shreg[0];
            state  <= ST_DATA;
          end
          ST_DATA: begin
            if (bit_idx == last_idx) begin
              line_q <= cfg_pen ? par_q : 1'b1;
              state  <= cfg_pen ? ST_PAR : ST_STOP;
            end else begin
              shreg   <= shreg >> 1;
              line_q  <= shreg[1];
              bit_idx <= bit_idx + 1'b1;
            end
          end
          ST_PAR: begin
            line_q <= 1'b1;
            state  <= ST_STOP;
          end
          default: begin
            line_q <= 1'b1;
            state  <= ST_IDLE;
          end
        endcase
      end
    end
  end

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!line_o && !in_ready));
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> line_q);
  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !baud_tick) |=> $stable(tick_cnt));
  p_bit_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_STOP) |-> (tick_cnt < CNT_W'(OVS)));
  p_cfg_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> $stable({cfg_wlen, cfg_stop, cfg_pen, par_q}));
endmodule

// File: rtl/txf_regwin.sv
module txf_regwin #(
  parameter int NREG   = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              div_win_i,
  output logic [NREG-1:0]   dsel_o,
  output logic [NREG-1:0]   vsel_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic hit;
    assign hit       = en_i && (addr_i == ADDR_W'(g));
    assign dsel_o[g] = hit && !div_win_i;
    assign vsel_o[g] = hit && div_win_i;
  end

  p_one_window_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vsel_o, dsel_o}));
  p_no_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> ({vsel_o, dsel_o} == '0));
endmodule

// File: rtl/uart_txf_top.sv
module uart_txf_top
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int NREG   = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        lcr_i,
  input  logic              baud_tick_i,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              reg_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  output logic              txd_o,
  output logic [NREG-1:0]   dsel_o,
  output logic [NREG-1:0]   vsel_o
);
  line_ctl_t ctl;
  logic      pbit;
  logic      frame_line;

  assign ctl = line_ctl_t'(lcr_i);

  txf_parity #(.DATA_W(DATA_W)) u_par (
    .data_i      (s_data),
    .wlen_i      (ctl.wlen),
    .par_even_i  (ctl.par_even),
    .force_par_i (ctl.force_par),
    .pbit_o      (pbit)
  );

  txf_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick_i),
    .in_valid    (s_valid),
    .in_ready    (s_ready),
    .in_data     (s_data),
    .wlen_i      (ctl.wlen),
    .long_stop_i (ctl.long_stop),
    .par_en_i    (ctl.par_en),
    .pbit_i      (pbit),
    .line_o      (frame_line)
  );

  txf_regwin #(.NREG(NREG), .ADDR_W(ADDR_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (reg_en_i),
    .addr_i    (reg_addr_i),
    .div_win_i (ctl.win_div),
    .dsel_o    (dsel_o),
    .vsel_o    (vsel_o)
  );

  assign txd_o = frame_line & ~ctl.brk;

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !ctl.brk && $past(s_ready)) |-> txd_o);
endmodule

// File: tb/uart_txf_top_tb.sv
module uart_txf_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lcr = 8'h00;
  logic       baud_tick = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'h00;
  logic       reg_en = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       txd;
  logic [2:0] dsel, vsel;

  int checks = 0;
  int failures = 0;
  int tick_num = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_txf_top u_dut (
    .clk(clk), .rst_n(rst_n), .lcr_i(lcr), .baud_tick_i(baud_tick),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .reg_en_i(reg_en), .reg_addr_i(reg_addr), .txd_o(txd),
    .dsel_o(dsel), .vsel_o(vsel)
  );

  always @(negedge clk) begin
    cyc++;
    baud_tick = rst_n && (cyc % 2 == 0);
    if (baud_tick) tick_num++;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits(input logic [7:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [7:0] c);
    logic x = 1'b0;
    for (int i = 0; i < nbits(c); i++) x ^= d[i];
    if (c[5]) return ~c[4];
    return c[4] ? x : ~x;
  endfunction

  function automatic int stop_ticks(input logic [7:0] c);
    if (!c[2]) return 16;
    return (c[1:0] == 2'b00) ? 24 : 32;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_tick(input int t);
    while (tick_num < t) step();
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [7:0] c,
                           input logic [7:0] cm, input bit use_mid);
    int t0, n, sidx, j;
    logic brk, e;
    step();
    while (!s_ready) step();
    lcr = c; s_data = d; s_valid = 1'b1; t0 = tick_num;
    step();
    s_valid = 1'b0;
    s_data = 8'($urandom);
    chk("R2 ready low after accept", {7'd0, s_ready}, 8'd0);
    n = nbits(c);
    sidx = n + 1 + (c[3] ? 1 : 0);
    wait_tick(t0 + 8);
    chk("R3 start bit", {7'd0, txd}, 8'd0);
    if (use_mid) lcr = cm;
    brk = use_mid ? cm[6] : c[6];
    for (j = 1; j <= n; j++) begin
      wait_tick(t0 + 16 * j + 8);
      e = brk ? 1'b0 : d[j-1];
      chk(brk ? "R11 break over data" : "R3 R12 data bit", {7'd0, txd}, {7'd0, e});
    end
    if (c[3]) begin
      wait_tick(t0 + 16 * (n + 1) + 8);
      e = brk ? 1'b0 : exp_par(d, c);
      case (c[5:4])
        2'b00: chk("R6 odd parity", {7'd0, txd}, {7'd0, e});
        2'b01: chk("R7 even parity", {7'd0, txd}, {7'd0, e});
        2'b10: chk("R8 mark parity", {7'd0, txd}, {7'd0, e});
        default: chk("R9 space parity", {7'd0, txd}, {7'd0, e});
      endcase
    end
    wait_tick(t0 + 16 * sidx + 8);
    chk("R5 R10 stop after last bit", {7'd0, txd}, {7'd0, ~brk});
    wait_tick(t0 + 16 * sidx + stop_ticks(c));
    chk("R4 R10 busy until last stop tick", {7'd0, s_ready}, 8'd0);
    step();
    chk("R10 ready after stop", {7'd0, s_ready}, 8'd1);
    lcr = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) step();
    chk("R1 reset line idle", {7'd0, txd}, 8'd1);
    chk("R1 reset ready", {7'd0, s_ready}, 8'd1);
    chk("R1 reset selects", {2'd0, vsel, dsel}, 8'd0);
    rst_n = 1'b1;
    step();

    // R13 register window steering, all combinations
    for (int a = 0; a < 8; a++) begin
      for (int m = 0; m < 4; m++) begin
        reg_addr = 3'(a); reg_en = m[0]; lcr = {m[1], 7'd0};
        step();
        chk("R13 data window", {5'd0, dsel},
            (m[0] && !m[1] && a < 3) ? (8'd1 << a) : 8'd0);
        chk("R13 divisor window", {5'd0, vsel},
            (m[0] && m[1] && a < 3) ? (8'd1 << a) : 8'd0);
      end
    end
    reg_en = 1'b0; lcr = 8'h00;

    // R11 break while idle takes effect at once and releases
    step(); lcr = 8'h40; #1;
    chk("R11 break idle low", {7'd0, txd}, 8'd0);
    lcr = 8'h00; #1;
    chk("R11 break released idle", {7'd0, txd}, 8'd1);

    // directed corner cases
    run_frame(8'hA5, 8'h03, 8'h00, 0);         // R5 8N1
    run_frame(8'h13, 8'h0B, 8'h00, 0);         // R6 odd, 8 bits
    run_frame(8'h13, 8'h1B, 8'h00, 0);         // R7 even
    run_frame(8'h00, 8'h2A, 8'h00, 0);         // R8 mark, 7 bits
    run_frame(8'hFF, 8'h39, 8'h00, 0);         // R9 space, 6 bits
    run_frame(8'h15, 8'h04, 8'h00, 0);         // R10 5 bits, 1.5 stop
    run_frame(8'h3C, 8'h0F, 8'h00, 0);         // R10 8 bits, 2 stop
    run_frame(8'hC3, 8'h0B, 8'h34, 1);         // R12 settings change mid-frame
    run_frame(8'h6E, 8'h0B, 8'h4B, 1);         // R11 break raised mid-frame
    run_frame(8'h91, 8'h4F, 8'h0F, 1);         // R11 break cleared mid-frame

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d, c;
      d = 8'($urandom);
      c = {1'b0, 1'b0, 6'($urandom)};
      run_frame(d, c, 8'h00, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule